// File: doc/BRIEF.md
# Fixed-Interval Timebase Tap Timer

This block holds a free-running 64-bit timebase that advances by one on every clock cycle in which the tick enable is high. A 2-bit period code picks one bit of that timebase from four tap positions. Each time the picked bit goes from 0 to 1, a sticky pending flag is set. The other timebase bits have no effect on this. The period is never switched off. Event detection keeps running whatever the interrupt enable holds. The enable only gates the level interrupt output, which is high while the flag and the enable are both set.

Software programs the period code and the interrupt enable through one control write port. It clears the pending flag through a status write port by writing a one. The flag lives in a two-state machine. `ST_CLEAR` moves to `ST_PENDING` on a tap event (transition `SET`). `ST_PENDING` returns to `ST_CLEAR` on a write-one clear in a cycle with no tap event (transition `ACK`). Every other case holds the current state (transition `HOLD`). When the period code changes, the stored previous value of the tap is reloaded from the newly picked bit. The change therefore takes effect at the next real rising edge of that bit and produces no false event.

Top module: `fit_tap_timer`

## Requirements
- R1: The timebase is TB_W bits wide (default 64) and resets to 0. It increases by exactly one on each rising clock edge where `tick_en` is 1 and holds its value otherwise. It can only be observed through tap events.
- R2: Period code 0, 1, 2 and 3 picks timebase bit TAP0, TAP1, TAP2 and TAP3 respectively (defaults 13, 17, 21, 25). A rising edge on a bit that is not picked causes no event.
- R3: A tap event occurs on every 0-to-1 change of the picked bit, whatever the other bits hold. It occurs whether or not the interrupt is enabled, and it makes `fit_pending` read 1 from the second clock edge after the timebase increment that raised the bit.
- R4: Once set, `fit_pending` stays 1 through later timebase activity until a write-one clear.
- R5: A status write (`stat_we`=1) with `stat_clr`=1 clears `fit_pending` at that edge. A status write with `stat_clr`=0 has no effect.
- R6: If a tap event and a write-one clear fall in the same cycle, the event wins and `fit_pending` stays 1.
- R7: `irq` is a level output equal to `fit_pending` AND the interrupt enable. Clearing either one drops `irq` after the same edge.
- R8: A control write that sets the enable while `fit_pending` is 1 raises `irq` right after that edge.
- R9: A change of period code creates no event when the newly picked bit is already 1. The next 0-to-1 change of the new bit does set `fit_pending`.
- R10: Reset clears `fit_pending`, the interrupt enable, the period code (to 0) and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase advance enable |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_period | input | 2 | Period code written on ctrl_we |
| ctrl_irq_en | input | 1 | Interrupt enable written on ctrl_we |
| stat_we | input | 1 | Status register write strobe |
| stat_clr | input | 1 | Write-one-to-clear bit for the pending flag |
| fit_pending | output | 1 | Sticky pending flag (status read value) |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets four cases. A switch to a tap bit that is already 1 must raise no flag; a design that forgot to reload the previous-value register would raise one. A clear that lands in the cycle of an event must leave the flag set; a design with the wrong priority would drop it and lose the event. Rising edges on bits that are not picked, for example tap 0 rising while code 1 is selected, must be ignored; a design with a faulty tap mux would respond to them. Turning the enable on over a pending flag must raise `irq` at once, and a design that sampled the enable late would show no interrupt until the next event. A mid-run reset checks that the counter, the code and the enable all restart from zero.

// File: rtl/fit_pkg.sv
package fit_pkg;
    localparam int PERIOD_W = 2;
    localparam int NUM_TAPS = 1 << PERIOD_W;

    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_PENDING = 1'b1
    } fit_state_e;
endpackage

// File: rtl/fit_timebase.sv
module fit_timebase #(
    parameter int TB_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    output logic [TB_W-1:0] tb_q
);
    localparam logic [TB_W-1:0] ONE = {{(TB_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n)       tb_q <= '0;
        else if (tick_en) tb_q <= tb_q + ONE;
    end

    p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (tb_q == $past(tb_q) + ONE));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(tb_q));
endmodule

// File: rtl/fit_tap_edge.sv
module fit_tap_edge
    import fit_pkg::*;
#(
    parameter int TB_W = 64,
    parameter int TAP0 = 13,
    parameter int TAP1 = 17,
    parameter int TAP2 = 21,
    parameter int TAP3 = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TB_W-1:0]     tb_q,
    input  logic [PERIOD_W-1:0] period_q,
    input  logic [PERIOD_W-1:0] period_d,
    output logic                tap_event
);
    localparam int TAP_POS [NUM_TAPS] = '{TAP0, TAP1, TAP2, TAP3};

    logic [NUM_TAPS-1:0] tap_now;
    logic                prev_q;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign tap_now[g] = tb_q[TAP_POS[g]];
    end

    // Previous value tracks the bit that will be selected next cycle, so a
    // period change reloads it from the new tap and no false edge appears.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= tap_now[period_d];
    end

    assign tap_event = tap_now[period_q] & ~prev_q;

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_event && period_d == period_q) |=> !tap_event);
endmodule

// File: rtl/fit_status_fsm.sv
module fit_status_fsm
    import fit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tap_event,
    input  logic clr_req,
    input  logic irq_en,
    output logic pending,
    output logic irq
);
    fit_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:   if (tap_event)               state_d = ST_PENDING; // SET
            ST_PENDING: if (clr_req && !tap_event)   state_d = ST_CLEAR;   // ACK, event wins
            default:                                 state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == ST_PENDING);
        irq     = pending & irq_en;
    end

    p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tap_event |=> pending);
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr_req) |=> pending);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && clr_req && !tap_event) |=> !pending);
    p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_event && clr_req) |=> pending);
endmodule

// File: rtl/fit_tap_timer.sv
module fit_tap_timer
    import fit_pkg::*;
#(
    parameter int TB_W = 64,
    parameter int TAP0 = 13,
    parameter int TAP1 = 17,
    parameter int TAP2 = 21,
    parameter int TAP3 = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       ctrl_we,
    input  logic [1:0] ctrl_period,
    input  logic       ctrl_irq_en,
    input  logic       stat_we,
    input  logic       stat_clr,
    output logic       fit_pending,
    output logic       irq
);
    logic [TB_W-1:0]     tb_q;
    logic [PERIOD_W-1:0] period_q, period_d;
    logic                irq_en_q;
    logic                tap_event;
    logic                clr_req;

    assign period_d = ctrl_we ? ctrl_period : period_q;
    assign clr_req  = stat_we & stat_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            irq_en_q <= 1'b0;
        end else if (ctrl_we) begin
            period_q <= ctrl_period;
            irq_en_q <= ctrl_irq_en;
        end
    end

    fit_timebase #(.TB_W(TB_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .tb_q    (tb_q)
    );

    fit_tap_edge #(
        .TB_W(TB_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tb_q      (tb_q),
        .period_q  (period_q),
        .period_d  (period_d),
        .tap_event (tap_event)
    );

    fit_status_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tap_event (tap_event),
        .clr_req   (clr_req),
        .irq_en    (irq_en_q),
        .pending   (fit_pending),
        .irq       (irq)
    );

    p_event_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tap_event |-> $past(tick_en));
    p_no_false_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_period != period_q && !tick_en) |=> !tap_event);
    p_irq_needs_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fit_pending);
    p_enable_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_irq_en && fit_pending && !clr_req) |=> irq);
endmodule

// File: tb/tb_fit_tap_timer.sv
module tb_fit_tap_timer;
    localparam int OP_TICK = 0;
    localparam int OP_CTRL = 1;
    localparam int OP_STAT = 2;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] n;
        logic [1:0]  per;
        logic        en;
        logic        clr;
        logic        exp_p;
        logic        exp_i;
        logic [3:0]  tag;
    } vec_t;

    // Taps overridden to bits 2,4,6,8 so events come quickly.
    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 16'd3,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 cnt 3
        '{2'd0, 16'd1,   2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 cnt 4, irq off
        '{2'd2, 16'd0,   2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 write zero
        '{2'd2, 16'd0,   2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5}, // R5 clear
        '{2'd0, 16'd4,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // cnt 8
        '{2'd0, 16'd4,   2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3}, // cnt 12
        '{2'd1, 16'd0,   2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd8}, // R8
        '{2'd1, 16'd0,   2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd7}, // R7 enable off
        '{2'd2, 16'd0,   2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
        '{2'd1, 16'd0,   2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},
        '{2'd0, 16'd4,   2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2}, // R2 cnt 16 bit4
        '{2'd2, 16'd0,   2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 flag off
        '{2'd0, 16'd4,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 bit2 ignored
        '{2'd1, 16'd0,   2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd0, 16'd44,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2}, // cnt 64 bit6
        '{2'd2, 16'd0,   2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
        '{2'd1, 16'd0,   2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd0, 16'd192, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2}, // cnt 256 bit8
        '{2'd2, 16'd0,   2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
        '{2'd0, 16'd16,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}, // cnt 272
        '{2'd1, 16'd0,   2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 bit4 already 1
        '{2'd0, 16'd16,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}, // cnt 288
        '{2'd0, 16'd16,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9}, // cnt 304 real edge
        '{2'd0, 16'd31,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4}  // R4 cnt 335 sticky
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [1:0] ctrl_period = '0;
    logic       ctrl_irq_en = 1'b0;
    logic       stat_we = 1'b0;
    logic       stat_clr = 1'b0;
    logic       fit_pending;
    logic       irq;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    fit_tap_timer #(.TB_W(64), .TAP0(2), .TAP1(4), .TAP2(6), .TAP3(8)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .ctrl_we(ctrl_we), .ctrl_period(ctrl_period), .ctrl_irq_en(ctrl_irq_en),
        .stat_we(stat_we), .stat_clr(stat_clr),
        .fit_pending(fit_pending), .irq(irq)
    );

    function automatic string req_name(int t);
        case (t)
            1: return "R1";  2: return "R2";  3: return "R3";
            4: return "R4";  5: return "R5";  6: return "R6";
            7: return "R7";  8: return "R8";  9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_tick(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        idle(2);
    endtask

    task automatic do_ctrl(input logic [1:0] per, input logic en);
        ctrl_we = 1'b1; ctrl_period = per; ctrl_irq_en = en;
        @(negedge clk);
        ctrl_we = 1'b0;
        idle(2);
    endtask

    task automatic do_stat(input logic clr);
        stat_we = 1'b1; stat_clr = clr;
        @(negedge clk);
        stat_we = 1'b0; stat_clr = 1'b0;
        idle(2);
    endtask

    initial begin
        idle(3);
        check(fit_pending, 1'b0, "R10", "pending at reset");
        check(irq, 1'b0, "R10", "irq at reset");
        rst_n = 1'b1;
        idle(2);

        for (int i = 0; i < NV; i++) begin
            case (int'(VEC[i].op))
                OP_TICK: do_tick(int'(VEC[i].n));
                OP_CTRL: do_ctrl(VEC[i].per, VEC[i].en);
                default: do_stat(VEC[i].clr);
            endcase
            check(fit_pending, VEC[i].exp_p, req_name(int'(VEC[i].tag)), $sformatf("pending row %0d", i));
            check(irq, VEC[i].exp_i, req_name(int'(VEC[i].tag)), $sformatf("irq row %0d", i));
        end

        // R6: count 335 -> 336 raises bit4; clear lands in the event cycle
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; stat_we = 1'b1; stat_clr = 1'b1;
        @(negedge clk);
        stat_we = 1'b0; stat_clr = 1'b0;
        idle(1);
        check(fit_pending, 1'b1, "R6", "event beats clear");
        do_stat(1'b1);
        check(fit_pending, 1'b0, "R5", "plain clear after R6");

        // count 336 -> 368 raises bit4 again
        do_tick(32);
        check(fit_pending, 1'b1, "R3", "bit4 at 368");

        // R10 / R1: mid-run reset restarts counter, code and enable
        rst_n = 1'b0;
        idle(2);
        check(fit_pending, 1'b0, "R10", "pending after reset");
        check(irq, 1'b0, "R10", "irq after reset");
        rst_n = 1'b1;
        idle(1);
        do_tick(3);
        check(fit_pending, 1'b0, "R1", "no event before count 4");
        do_tick(1);
        check(fit_pending, 1'b1, "R1", "tap0 event at count 4 after reset");
        check(irq, 1'b0, "R10", "enable cleared by reset");

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule